// File: doc/BRIEF.md
# Per-Port Computation Unit Controller

This controller steps one function unit through four phases: issue, operand read, execution and result write. Each register-file port has its own request and grant handshake. At issue the unit records which read ports the instruction needs and which write ports it reserves. It raises one read request for each needed port and takes in the operand for a port in the cycle that port's go-read pulse arrives. It does not wait for every port to be granted together.

Once every operand has arrived, the execution pipeline reports completion. It also gives a result-valid flag for each write port. A reserved port whose flag is low has its write hazard released at once and never raises a write request. The remaining ports each request a write and wait for their own go-write pulse. The unit leaves the busy state as soon as every reservation has been either granted or released. If every reservation is released at completion, the unit frees itself in that same step and does not hold a port forever.

Top module: `cu_port_ctrl`

## Requirements
- R1: After reset, busy_o, opnd_ok_o, rd_req_o, wr_req_o and wr_hazard_o are all zero.
- R2: An issue_i pulse while busy_o is low sets busy_o, rd_req_o = rd_need_i and wr_hazard_o = wr_need_i in the next cycle. wr_req_o stays zero.
- R3: An issue_i pulse while busy_o is high is ignored. Read requests, hazards and write requests do not change because of it.
- R4: A go_rd_i[k] pulse while rd_req_o[k] is high copies slice k of rd_data_i (bits k*DW_W+:DW_W) into the same slice of opnd_o and clears rd_req_o[k] in the next cycle. Every other port is unaffected. A go_rd_i[k] pulse while rd_req_o[k] is low changes neither rd_req_o nor opnd_o.
- R5: opnd_ok_o is high exactly when the unit is busy, has not yet accepted completion, and has no read request outstanding.
- R6: pipe_done_i while opnd_ok_o is high is accepted. In the next cycle wr_hazard_o and wr_req_o both equal the previous wr_hazard_o AND res_valid_i, and opnd_ok_o is low.
- R7: A write request stays high until its go_write pulse arrives. A go_wr_i[k] pulse while wr_req_o[k] is high clears wr_req_o[k] and wr_hazard_o[k] in the next cycle. A go_wr_i pulse on a port with no request has no effect.
- R8: While wr_req_o[k] is high, slice k of wr_data_o holds slice k of res_data_i as captured at completion.
- R9: busy_o falls in the cycle after the last outstanding write is granted. If no reserved port is valid at completion, busy_o falls in the cycle after completion.
- R10: pipe_done_i while opnd_ok_o is low is ignored. No write request rises and the hazards keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Issue pulse |
| rd_need_i | input | N_RD | Read ports the instruction needs |
| wr_need_i | input | N_WR | Write ports the instruction reserves |
| rd_req_o | output | N_RD | Outstanding read request per port |
| go_rd_i | input | N_RD | Go-read grant per port |
| rd_data_i | input | N_RD*DW_W | Register-file read data, one slice per port |
| opnd_o | output | N_RD*DW_W | Captured operands |
| opnd_ok_o | output | 1 | All operands present, completion may be reported |
| pipe_done_i | input | 1 | Pipeline completion |
| res_valid_i | input | N_WR | Per-port result-valid flags |
| res_data_i | input | N_WR*DW_W | Pipeline results, one slice per port |
| wr_hazard_o | output | N_WR | Write reservations still held |
| wr_req_o | output | N_WR | Outstanding write request per port |
| go_wr_i | input | N_WR | Go-write grant per port |
| wr_data_o | output | N_WR*DW_W | Result data for each requested write |
| busy_o | output | 1 | Unit occupied |

## Verification
The hardest situation to reach from the ports is completion with reserved ports whose valid flags are low, and in particular the case where every reserved port is invalid. Only in that case can the unit free itself without any write grant. The stimulus sweeps every combination of read needs, write reservations and result-valid flags on a three-read, three-write configuration, so the all-released case comes up for every reservation set. Grants on ports with no request, and issue and completion pulses at the wrong phase, are mixed into the sweep.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPER = 2'd1,
    PH_WB   = 2'd2
  } phase_e;
endpackage

// File: rtl/cu_rd_lane.sv
module cu_rd_lane #(
  parameter int DW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            need_i,
  input  logic            go_i,
  input  logic [DW_W-1:0] data_i,
  output logic            pend_o,
  output logic [DW_W-1:0] opnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      opnd_o <= '0;
    end else if (load_i) begin
      pend_o <= need_i;
    end else if (go_i && pend_o) begin
      pend_o <= 1'b0;
      opnd_o <= data_i;
    end
  end
endmodule

// File: rtl/cu_wr_lane.sv
module cu_wr_lane #(
  parameter int DW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            need_i,
  input  logic            done_i,
  input  logic            valid_i,
  input  logic [DW_W-1:0] data_i,
  input  logic            go_i,
  output logic            resv_o,
  output logic            req_o,
  output logic [DW_W-1:0] data_o
);
  logic keep;
  assign keep = resv_o && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resv_o <= 1'b0;
      req_o  <= 1'b0;
      data_o <= '0;
    end else if (load_i) begin
      resv_o <= need_i;
      req_o  <= 1'b0;
    end else if (done_i) begin
      // unused reservation released here, never requested
      resv_o <= keep;
      req_o  <= keep;
      if (keep) data_o <= data_i;
    end else if (go_i && req_o) begin
      resv_o <= 1'b0;
      req_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/cu_seq.sv
module cu_seq
  import cu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  input  logic rd_left_i,
  input  logic keep_any_i,
  input  logic wr_left_i,
  output logic load_o,
  output logic done_acc_o,
  output logic opnd_ok_o,
  output logic busy_o
);
  phase_e phase_q, phase_d;

  assign load_o     = issue_i && (phase_q == PH_IDLE);
  assign opnd_ok_o  = (phase_q == PH_OPER) && !rd_left_i;
  assign done_acc_o = done_i && opnd_ok_o;
  assign busy_o     = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (load_o) phase_d = PH_OPER;
      PH_OPER: if (done_acc_o) phase_d = keep_any_i ? PH_WB : PH_IDLE;
      PH_WB:   if (!wr_left_i) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/cu_port_ctrl.sv
module cu_port_ctrl #(
  parameter int N_RD = 6,
  parameter int N_WR = 5,
  parameter int DW_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 issue_i,
  input  logic [N_RD-1:0]      rd_need_i,
  input  logic [N_WR-1:0]      wr_need_i,
  output logic [N_RD-1:0]      rd_req_o,
  input  logic [N_RD-1:0]      go_rd_i,
  input  logic [N_RD*DW_W-1:0] rd_data_i,
  output logic [N_RD*DW_W-1:0] opnd_o,
  output logic                 opnd_ok_o,
  input  logic                 pipe_done_i,
  input  logic [N_WR-1:0]      res_valid_i,
  input  logic [N_WR*DW_W-1:0] res_data_i,
  output logic [N_WR-1:0]      wr_hazard_o,
  output logic [N_WR-1:0]      wr_req_o,
  input  logic [N_WR-1:0]      go_wr_i,
  output logic [N_WR*DW_W-1:0] wr_data_o,
  output logic                 busy_o
);
  logic load, done_acc;
  logic keep_any, wr_left;

  assign keep_any = |(wr_hazard_o & res_valid_i);
  assign wr_left  = |(wr_req_o & ~go_wr_i);

  cu_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_i),
    .done_i     (pipe_done_i),
    .rd_left_i  (|rd_req_o),
    .keep_any_i (keep_any),
    .wr_left_i  (wr_left),
    .load_o     (load),
    .done_acc_o (done_acc),
    .opnd_ok_o  (opnd_ok_o),
    .busy_o     (busy_o)
  );

  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    cu_rd_lane #(.DW_W(DW_W)) u_rd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .need_i (rd_need_i[k]),
      .go_i   (go_rd_i[k]),
      .data_i (rd_data_i[k*DW_W +: DW_W]),
      .pend_o (rd_req_o[k]),
      .opnd_o (opnd_o[k*DW_W +: DW_W])
    );
  end

  for (genvar k = 0; k < N_WR; k++) begin : g_wr
    cu_wr_lane #(.DW_W(DW_W)) u_wr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .need_i  (wr_need_i[k]),
      .done_i  (done_acc),
      .valid_i (res_valid_i[k]),
      .data_i  (res_data_i[k*DW_W +: DW_W]),
      .go_i    (go_wr_i[k]),
      .resv_o  (wr_hazard_o[k]),
      .req_o   (wr_req_o[k]),
      .data_o  (wr_data_o[k*DW_W +: DW_W])
    );
  end
endmodule

// File: rtl/cu_port_ctrl_chk.sv
module cu_port_ctrl_chk #(
  parameter int N_RD = 6,
  parameter int N_WR = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_RD-1:0] rd_req_o,
  input logic [N_RD-1:0] go_rd_i,
  input logic            opnd_ok_o,
  input logic            pipe_done_i,
  input logic [N_WR-1:0] res_valid_i,
  input logic [N_WR-1:0] wr_hazard_o,
  input logic [N_WR-1:0] wr_req_o,
  input logic [N_WR-1:0] go_wr_i,
  input logic            busy_o
);
  a_r1_idle_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_req_o == '0 && wr_req_o == '0 && wr_hazard_o == '0));

  a_r3_no_new_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ((wr_hazard_o & ~$past(wr_hazard_o)) == '0));

  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_req_o & go_rd_i) != '0) |=> ((rd_req_o & $past(rd_req_o & go_rd_i)) == '0));

  a_r5_opnd_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_ok_o |-> (busy_o && rd_req_o == '0 && wr_req_o == '0));

  a_r6_drop_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_done_i && opnd_ok_o) |=>
      (wr_hazard_o == ($past(wr_hazard_o) & $past(res_valid_i)) && wr_req_o == wr_hazard_o));

  a_r7_req_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_req_o & ~go_wr_i) != '0) |=> (($past(wr_req_o & ~go_wr_i) & ~wr_req_o) == '0));

  a_r7_req_in_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o & ~wr_hazard_o) == '0);

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o != '0 && (wr_req_o & ~go_wr_i) == '0) |=> !busy_o);

  a_r10_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_done_i && busy_o && !opnd_ok_o && wr_req_o == '0) |=> (wr_req_o == '0));
endmodule

bind cu_port_ctrl cu_port_ctrl_chk #(.N_RD(N_RD), .N_WR(N_WR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_o    (rd_req_o),
  .go_rd_i     (go_rd_i),
  .opnd_ok_o   (opnd_ok_o),
  .pipe_done_i (pipe_done_i),
  .res_valid_i (res_valid_i),
  .wr_hazard_o (wr_hazard_o),
  .wr_req_o    (wr_req_o),
  .go_wr_i     (go_wr_i),
  .busy_o      (busy_o)
);

// File: tb/cu_port_ctrl_tb_top.sv
module cu_port_ctrl_tb_top;
  localparam int NR = 3;
  localparam int NW = 3;
  localparam int DW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue = 1'b0;
  logic [NR-1:0]     rd_need = '0;
  logic [NW-1:0]     wr_need = '0;
  logic [NR-1:0]     rd_req;
  logic [NR-1:0]     go_rd = '0;
  logic [NR*DW-1:0]  rd_data = '0;
  logic [NR*DW-1:0]  opnd;
  logic              opnd_ok;
  logic              pipe_done = 1'b0;
  logic [NW-1:0]     res_valid = '0;
  logic [NW*DW-1:0]  res_data = '0;
  logic [NW-1:0]     hazard;
  logic [NW-1:0]     wr_req;
  logic [NW-1:0]     go_wr = '0;
  logic [NW*DW-1:0]  wr_data;
  logic              busy;

  int n_chk = 0;
  int n_bad = 0;
  logic [NR*DW-1:0] exp_opnd = '0;

  always #10 clk = ~clk;

  cu_port_ctrl #(.N_RD(NR), .N_WR(NW), .DW_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .rd_need_i(rd_need),
    .wr_need_i(wr_need), .rd_req_o(rd_req), .go_rd_i(go_rd),
    .rd_data_i(rd_data), .opnd_o(opnd), .opnd_ok_o(opnd_ok),
    .pipe_done_i(pipe_done), .res_valid_i(res_valid), .res_data_i(res_data),
    .wr_hazard_o(hazard), .wr_req_o(wr_req), .go_wr_i(go_wr),
    .wr_data_o(wr_data), .busy_o(busy)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [NR-1:0] rpend;
    logic [NW-1:0] keep;
    logic [NW-1:0] wleft;
    int t;
    #35;
    chk(busy == 0 && opnd_ok == 0 && rd_req == 0 && wr_req == 0 && hazard == 0,
        "R1 reset", {busy, opnd_ok, rd_req, wr_req, hazard}, 0);
    rst_n = 1'b1;
    tick();

    // directed: issue while busy, completion before operands
    issue = 1; rd_need = 3'b111; wr_need = 3'b101; tick(); issue = 0;
    chk(rd_req == 3'b111 && hazard == 3'b101 && busy, "R2 issue", {rd_req, hazard}, {3'b111, 3'b101});
    issue = 1; rd_need = 3'b000; wr_need = 3'b010; tick(); issue = 0;
    chk(rd_req == 3'b111 && hazard == 3'b101, "R3 issue while busy", {rd_req, hazard}, {3'b111, 3'b101});
    pipe_done = 1; res_valid = 3'b111; tick(); pipe_done = 0;
    chk(wr_req == 0 && hazard == 3'b101 && !opnd_ok, "R10 early done", {wr_req, hazard}, {3'b000, 3'b101});
    go_rd = 3'b111; rd_data = {8'hc3, 8'hb2, 8'ha1}; tick(); go_rd = 0;
    exp_opnd = rd_data;
    chk(rd_req == 0 && opnd == exp_opnd && opnd_ok, "R4 all read", opnd, exp_opnd);
    pipe_done = 1; res_valid = 3'b000; tick(); pipe_done = 0;
    chk(!busy && hazard == 0 && wr_req == 0, "R9 all dropped", {busy, hazard}, 0);

    // sweep
    t = 0;
    for (int rn = 0; rn < (1 << NR); rn++) begin
      for (int wn = 0; wn < (1 << NW); wn++) begin
        for (int vn = 0; vn < (1 << NW); vn++) begin
          t++;
          issue = 1; rd_need = NR'(rn); wr_need = NW'(wn); tick(); issue = 0;
          chk(busy && rd_req == NR'(rn) && hazard == NW'(wn) && wr_req == 0,
              "R2 issue", {busy, rd_req, hazard, wr_req}, {1'b1, NR'(rn), NW'(wn), NW'(0)});
          chk(opnd_ok == (rn == 0), "R5 opnd_ok after issue", opnd_ok, rn == 0);
          // grants on idle read ports
          go_rd = ~NR'(rn); rd_data = {NR{8'(t * 3 + 17)}}; tick(); go_rd = 0;
          chk(rd_req == NR'(rn) && opnd == exp_opnd, "R4 ignore ungranted", opnd, exp_opnd);
          rpend = NR'(rn);
          for (int k = 0; k < NR; k++) begin
            if (rpend[k]) begin
              for (int j = 0; j < NR; j++) rd_data[j*DW +: DW] = 8'(t * 7 + j * 31 + 1);
              go_rd = NR'(1) << k; tick(); go_rd = 0;
              exp_opnd[k*DW +: DW] = 8'(t * 7 + k * 31 + 1);
              rpend[k] = 1'b0;
              chk(rd_req == rpend && opnd == exp_opnd, "R4 read grant", {rd_req, opnd}, {rpend, exp_opnd});
              chk(opnd_ok == (rpend == 0), "R5 opnd_ok", opnd_ok, rpend == 0);
            end
          end
          for (int j = 0; j < NW; j++) res_data[j*DW +: DW] = 8'(t * 13 + j * 5 + 3);
          pipe_done = 1; res_valid = NW'(vn); tick(); pipe_done = 0;
          keep = NW'(wn) & NW'(vn);
          chk(wr_req == keep && hazard == keep && !opnd_ok, "R6 completion", {wr_req, hazard}, {keep, keep});
          chk(busy == (keep != 0), "R9 busy after completion", busy, keep != 0);
          for (int j = 0; j < NW; j++)
            if (keep[j])
              chk(wr_data[j*DW +: DW] == 8'(t * 13 + j * 5 + 3), "R8 write data",
                  wr_data[j*DW +: DW], 8'(t * 13 + j * 5 + 3));
          wleft = keep;
          if (keep != 0) begin
            go_wr = ~keep; tick(); go_wr = 0;
            chk(wr_req == keep && busy, "R7 ignore ungranted write", wr_req, keep);
          end
          for (int k = 0; k < NW; k++) begin
            if (wleft[k]) begin
              go_wr = NW'(1) << k; tick(); go_wr = 0;
              wleft[k] = 1'b0;
              chk(wr_req == wleft && hazard == wleft, "R7 write grant", wr_req, wleft);
              chk(busy == (wleft != 0), "R9 busy release", busy, wleft != 0);
            end
          end
        end
      end
    end
    summary();
  end
endmodule